// File: doc/BRIEF.md
# Strap-Configured Microcontroller Bus Slave Bridge

This block lets an external microcontroller read and write an internal 16-bit register file through one of several bus conventions. Three strap inputs are captured during reset and held until the next reset. The first strap picks the bus arrangement. With separate buses there is a dedicated 8-bit address bus and a 16-bit data bus. With a multiplexed bus, one 8-bit bus carries both address and data, and the 16-bit lines are left free for another data path. The second strap picks the strobe convention. The third strap picks how the address is captured when the bus is multiplexed.

All bus pins first pass through a two-stage pipeline that aligns them with the internal clock. A write is committed exactly once, when the write qualifier ends. A read issues one read request to the register port when the read qualifier begins, and the returned word is held for the bus. The bus pins are modelled as input, output and output-enable triples. Each output enable is raised only while chip select and the read qualifier are both active at the pins.

Top module: `mcu_bus_bridge`

## Requirements
- R1: The straps `strap_sep`, `strap_split` and `strap_ale` are captured on every clock edge while `rst` is high. After reset is released, changing them has no effect until the next reset.
- R2: In separate mode (`strap_sep`=1), a write stores the 16-bit `data_in` at address `addr_in`. It produces exactly one `reg_we` pulse, issued after the write qualifier ends.
- R3: In separate mode, a read produces one `reg_re` pulse at address `addr_in`. `data_out` then shows the full 16-bit `reg_rdata`. `data_oe` is high while the read qualifier is held, and `ad_oe` stays low.
- R4: When `strap_split`=1, `rd_dir` is an active-low read strobe and `wr_ds_n` is an active-low write strobe. When `strap_split`=0, `wr_ds_n` is an active-low data strobe and `rd_dir` gives the direction, with 1 meaning read and 0 meaning write.
- R5: While `cs_n` is high, strobes are ignored. No `reg_we` or `reg_re` is issued, and neither output enable rises.
- R6: In multiplexed mode with `strap_ale`=1, the address is taken from `ad_in` while `addr_qual` (ALE) is high with `cs_n` low. Write data is `ad_in` zero-extended to 16 bits. A read returns the low byte of the register on `ad_out`, with `ad_oe` high.
- R7: In multiplexed mode with `strap_ale`=0, `addr_qual` acts as an address bit. A write with `addr_qual`=0 loads an internal pointer and issues no `reg_we`. An access with `addr_qual`=1 targets the register at that pointer. A read with `addr_qual`=0 returns the pointer, zero-extended, and issues no `reg_re`.
- R8: In multiplexed mode, `data_oe` stays low and `data_in` has no effect on what is written.
- R9: Each write strobe commits at most once, and `reg_we` and `reg_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset; straps are captured while high |
| strap_sep | input | 1 | Bus arrangement strap: 1 separate, 0 multiplexed |
| strap_split | input | 1 | Strobe strap: 1 read/write strobes, 0 direction plus data strobe |
| strap_ale | input | 1 | Address capture strap (multiplexed): 1 ALE pulse, 0 address bit |
| cs_n | input | 1 | Active-low chip select |
| rd_dir | input | 1 | Read strobe (active low) or direction line (1 = read) |
| wr_ds_n | input | 1 | Active-low write strobe or data strobe |
| addr_qual | input | 1 | ALE or address bit, in multiplexed mode |
| addr_in | input | 8 | Address bus, separate mode |
| ad_in | input | 8 | Multiplexed bus, incoming |
| ad_out | output | 8 | Multiplexed bus, outgoing read data |
| ad_oe | output | 1 | Drive enable for the multiplexed bus |
| data_in | input | 16 | 16-bit data bus, incoming |
| data_out | output | 16 | 16-bit data bus, outgoing read data |
| data_oe | output | 1 | Drive enable for the 16-bit data bus |
| reg_addr | output | 8 | Register port address |
| reg_wdata | output | 16 | Register port write data |
| reg_we | output | 1 | Register port write pulse |
| reg_re | output | 1 | Register port read pulse |
| reg_rdata | input | 16 | Register port read data, valid in the `reg_re` cycle |

## Verification
The assertions assume that the register port returns `reg_rdata` combinationally for the presented `reg_addr`. They also assume a well-formed processor: it never asserts the read and write qualifiers together, and it holds address, data and the qualifier pins steady for several clocks around each strobe. The bench keeps within these assumptions. Every strobe lasts at least six clocks, chip select brackets every strobe with margin on both sides, and the straps change only with reset high, except in the one test that deliberately moves them afterwards.

// File: rtl/mbb_pkg.sv
package mbb_pkg;

    typedef enum logic { BUS_MUX = 1'b0, BUS_SEP = 1'b1 } bus_mode_t;
    typedef enum logic { STB_DIRDS = 1'b0, STB_RDWR = 1'b1 } strobe_t;
    typedef enum logic { CAP_ABIT = 1'b0, CAP_ALE = 1'b1 } capture_t;

    typedef struct packed {
        bus_mode_t bus;
        strobe_t   stb;
        capture_t  cap;
    } cfg_t;

    // Read qualifier from the two strobe pins under a given convention
    function automatic logic rd_req(strobe_t s, logic p_a, logic p_b);
        return (s == STB_RDWR) ? !p_a : (p_a && !p_b);
    endfunction

    // Write qualifier from the two strobe pins under a given convention
    function automatic logic wr_req(strobe_t s, logic p_a, logic p_b);
        return (s == STB_RDWR) ? !p_b : (!p_a && !p_b);
    endfunction

endpackage

// File: rtl/mbb_straps.sv
module mbb_straps
    import mbb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strap_sep,
    input  logic strap_split,
    input  logic strap_ale,
    output cfg_t cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '{bus: strap_sep   ? BUS_SEP  : BUS_MUX,
                     stb: strap_split ? STB_RDWR : STB_DIRDS,
                     cap: strap_ale   ? CAP_ALE  : CAP_ABIT};
        end
    end

    // R1: configuration frozen once reset has been released
    a_r1_cfg_held: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(cfg));

endmodule

// File: rtl/mbb_sync.sv
module mbb_sync #(
    parameter int             W       = 8,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] st [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) st[i] <= RST_VAL;
                else     st[i] <= (i == 0) ? d : st[(i == 0) ? 0 : i - 1];
            end
        end
    endgenerate

    assign q = st[STAGES-1];

endmodule

// File: rtl/mbb_edge.sv
module mbb_edge
    import mbb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  strobe_t stb,
    input  logic    cs_n_s,
    input  logic    pa_s,
    input  logic    pb_s,
    output logic    rd_act,
    output logic    wr_act,
    output logic    rd_start,
    output logic    wr_commit
);

    logic rd_prev;
    logic wr_prev;

    assign rd_act    = !cs_n_s && rd_req(stb, pa_s, pb_s);
    assign wr_act    = !cs_n_s && wr_req(stb, pa_s, pb_s);
    assign rd_start  = rd_act && !rd_prev;
    assign wr_commit = wr_prev && !wr_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_prev <= 1'b0;
            wr_prev <= 1'b0;
        end else begin
            rd_prev <= rd_act;
            wr_prev <= wr_act;
        end
    end

endmodule

// File: rtl/mcu_bus_bridge.sv
module mcu_bus_bridge
    import mbb_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strap_sep,
    input  logic          strap_split,
    input  logic          strap_ale,
    input  logic          cs_n,
    input  logic          rd_dir,
    input  logic          wr_ds_n,
    input  logic          addr_qual,
    input  logic [AW-1:0] addr_in,
    input  logic [AW-1:0] ad_in,
    output logic [AW-1:0] ad_out,
    output logic          ad_oe,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_we,
    output logic          reg_re,
    input  logic [DW-1:0] reg_rdata
);

    localparam int SW = 4 + 2 * AW + DW;
    localparam logic [SW-1:0] SYNC_RST = {4'b1110, {(2 * AW + DW){1'b0}}};

    cfg_t cfg;

    mbb_straps u_straps (
        .clk         (clk),
        .rst         (rst),
        .strap_sep   (strap_sep),
        .strap_split (strap_split),
        .strap_ale   (strap_ale),
        .cfg         (cfg)
    );

    // All pins travel through the same pipeline so data stays aligned with strobes
    logic [SW-1:0] sync_q;
    logic          s_cs_n, s_pa, s_pb, s_qual;
    logic [AW-1:0] s_ad, s_addr;
    logic [DW-1:0] s_data;

    mbb_sync #(.W(SW), .STAGES(2), .RST_VAL(SYNC_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, rd_dir, wr_ds_n, addr_qual, ad_in, addr_in, data_in}),
        .q   (sync_q)
    );

    assign {s_cs_n, s_pa, s_pb, s_qual, s_ad, s_addr, s_data} = sync_q;

    logic rd_act, wr_act, rd_start, wr_commit;

    mbb_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .stb       (cfg.stb),
        .cs_n_s    (s_cs_n),
        .pa_s      (s_pa),
        .pb_s      (s_pb),
        .rd_act    (rd_act),
        .wr_act    (wr_act),
        .rd_start  (rd_start),
        .wr_commit (wr_commit)
    );

    logic is_mux, is_abit;
    assign is_mux  = (cfg.bus == BUS_MUX);
    assign is_abit = is_mux && (cfg.cap == CAP_ABIT);

    // Capture state for the access in progress
    logic [DW-1:0] lat_data;
    logic [AW-1:0] lat_addr;
    logic          lat_qual;
    logic [AW-1:0] ale_addr;
    logic [AW-1:0] ptr;
    logic [DW-1:0] rd_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_data <= '0;
            lat_addr <= '0;
            lat_qual <= 1'b0;
            ale_addr <= '0;
            ptr      <= '0;
        end else begin
            if (wr_act) begin
                lat_data <= is_mux ? DW'(s_ad) : s_data;
                lat_addr <= s_addr;
                lat_qual <= s_qual;
            end
            if (is_mux && cfg.cap == CAP_ALE && !s_cs_n && s_qual)
                ale_addr <= s_ad;
            if (wr_commit && is_abit && !lat_qual)
                ptr <= lat_data[AW-1:0];
        end
    end

    logic [AW-1:0] wr_target, rd_target, mux_target;
    logic          wr_to_reg, rd_to_reg, ptr_read;

    always_comb begin
        mux_target = (cfg.cap == CAP_ALE) ? ale_addr : ptr;
        wr_target  = is_mux ? mux_target : lat_addr;
        rd_target  = is_mux ? mux_target : s_addr;
        wr_to_reg  = wr_commit && !(is_abit && !lat_qual);
        ptr_read   = rd_start && is_abit && !s_qual;
        rd_to_reg  = rd_start && !ptr_read;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_we    <= 1'b0;
            reg_re    <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
            rd_hold   <= '0;
        end else begin
            reg_we <= wr_to_reg;
            reg_re <= rd_to_reg && !wr_to_reg;
            if (wr_to_reg) begin
                reg_addr  <= wr_target;
                reg_wdata <= lat_data;
            end else if (rd_to_reg) begin
                reg_addr  <= rd_target;
            end
            if (reg_re)
                rd_hold <= is_mux ? DW'(reg_rdata[AW-1:0]) : reg_rdata;
            else if (ptr_read)
                rd_hold <= DW'(ptr);
        end
    end

    // Bus drive: straight from the pins so the bus is released without delay
    logic pin_rd;
    assign pin_rd   = rd_req(cfg.stb, rd_dir, wr_ds_n);
    assign data_oe  = !is_mux && !cs_n && pin_rd;
    assign ad_oe    = is_mux && !cs_n && pin_rd;
    assign data_out = rd_hold;
    assign ad_out   = rd_hold[AW-1:0];

    // R9: write and read requests never collide
    a_r9_we_re_excl: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_re));

    // R2 / R9: one strobe gives a single-cycle write pulse
    a_r2_we_single: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    // R5: a write only follows a chip-selected access
    a_r5_we_needs_cs: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> !$past(s_cs_n, 2));

    // R8: the wide data bus is never driven in multiplexed mode
    a_r8_mux_no_data_oe: assert property (@(posedge clk) disable iff (rst)
        (cfg.bus == BUS_MUX) |-> !data_oe);

    // R3: the multiplexed bus is never driven in separate mode
    a_r3_sep_no_ad_oe: assert property (@(posedge clk) disable iff (rst)
        (cfg.bus == BUS_SEP) |-> !ad_oe);

endmodule

// File: tb/tb_mcu_bus_bridge.sv
`timescale 1ns/1ps
module tb_mcu_bus_bridge;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_sep = 1'b1, strap_split = 1'b1, strap_ale = 1'b0;
    logic        cs_n = 1'b1, rd_dir = 1'b1, wr_ds_n = 1'b1, addr_qual = 1'b0;
    logic [7:0]  addr_in = '0, ad_in = '0, ad_out;
    logic        ad_oe, data_oe;
    logic [15:0] data_in = '0, data_out;
    logic [7:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic        reg_we, reg_re;

    logic [15:0] mem [256];
    logic [15:0] expm [256];
    int          we_cnt = 0, re_cnt = 0;
    int          nchk = 0, nfail = 0;
    bit          m_sep, m_split, m_ale;

    always #2 clk = ~clk;

    mcu_bus_bridge dut (
        .clk(clk), .rst(rst), .strap_sep(strap_sep), .strap_split(strap_split),
        .strap_ale(strap_ale), .cs_n(cs_n), .rd_dir(rd_dir), .wr_ds_n(wr_ds_n),
        .addr_qual(addr_qual), .addr_in(addr_in), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
        .reg_rdata(reg_rdata)
    );

    assign reg_rdata = mem[reg_addr];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= 16'h0;
        end else if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
        end
        if (reg_we) we_cnt <= we_cnt + 1;
        if (reg_re) re_cnt <= re_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit sep, input bit split, input bit ale);
        @(negedge clk);
        m_sep = sep; m_split = split; m_ale = ale;
        strap_sep = sep; strap_split = split; strap_ale = ale;
        cs_n = 1'b1; rd_dir = 1'b1; wr_ds_n = 1'b1; addr_qual = 1'b0;
        rst = 1'b1;
        for (int i = 0; i < 256; i++) expm[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // R4: strobe conventions
    task automatic strobe_on(input bit rd);
        if (m_split) begin
            if (rd) rd_dir = 1'b0; else wr_ds_n = 1'b0;
        end else begin
            rd_dir = rd;
            @(negedge clk);
            wr_ds_n = 1'b0;
        end
    endtask

    task automatic strobe_off();
        if (m_split) begin
            rd_dir = 1'b1; wr_ds_n = 1'b1;
        end else begin
            wr_ds_n = 1'b1;
            @(negedge clk);
            rd_dir = 1'b1;
        end
    endtask

    task automatic bus_wr(input bit qual, input logic [15:0] val, input bit sel);
        cs_n = sel ? 1'b0 : 1'b1;
        if (!m_ale || m_sep) addr_qual = qual;
        if (m_sep) data_in = val;
        else begin ad_in = val[7:0]; data_in = 16'hDEAD; end
        @(negedge clk);
        strobe_on(1'b0);
        repeat (6) @(negedge clk);
        strobe_off();
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic bus_rd(input bit qual, output logic [15:0] v, output bit oe_ok, output bit oe_off);
        cs_n = 1'b0;
        if (!m_ale || m_sep) addr_qual = qual;
        @(negedge clk);
        strobe_on(1'b1);
        repeat (8) @(negedge clk);
        v = m_sep ? data_out : {8'h00, ad_out};
        oe_ok = m_sep ? (data_oe && !ad_oe) : (ad_oe && !data_oe);
        strobe_off();
        @(negedge clk);
        oe_off = !data_oe && !ad_oe;
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic ale_phase(input logic [7:0] a);
        cs_n = 1'b0;
        ad_in = a;
        addr_qual = 1'b1;
        repeat (4) @(negedge clk);
        addr_qual = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic acc_write(input logic [7:0] a, input logic [15:0] d);
        int w0;
        logic [15:0] e;
        w0 = we_cnt;
        e = m_sep ? d : {8'h00, d[7:0]};
        addr_in = a;
        if (m_sep) bus_wr(1'b0, d, 1'b1);
        else if (m_ale) begin ale_phase(a); bus_wr(1'b0, d, 1'b1); end
        else begin
            bus_wr(1'b0, {8'h00, a}, 1'b1);
            chk(we_cnt == w0, "R7 pointer load issues no write", we_cnt - w0, 0);
            bus_wr(1'b1, d, 1'b1);
        end
        expm[a] = e;
        chk(mem[a] === e, m_sep ? "R2 write stored" : (m_ale ? "R6 write stored" : "R7 write stored"), mem[a], e);
        chk(we_cnt == w0 + 1, "R9 one commit per write", we_cnt - w0, 1);
    endtask

    task automatic acc_read(input logic [7:0] a);
        int r0;
        logic [15:0] v, e;
        bit ok, off;
        r0 = re_cnt;
        addr_in = a;
        if (!m_sep && m_ale) ale_phase(a);
        if (!m_sep && !m_ale) bus_wr(1'b0, {8'h00, a}, 1'b1);
        bus_rd(1'b1, v, ok, off);
        e = m_sep ? expm[a] : {8'h00, expm[a][7:0]};
        chk(v === e, m_sep ? "R3 read data" : "R6/R7 read low byte", v, e);
        chk(ok && off, m_sep ? "R3 output enable window" : "R8 mux drive only", {ok, off}, 2'b11);
        chk(re_cnt == r0 + 1, "R3 one read request", re_cnt - r0, 1);
    endtask

    initial begin
        logic [15:0] v;
        bit ok, off;
        int w0, r0, cfgi;

        do_reset(1'b1, 1'b1, 1'b0);
        chk(!reg_we && !reg_re && !data_oe && !ad_oe, "R5 reset idle outputs",
            {reg_we, reg_re, data_oe, ad_oe}, 0);

        cfgi = 0;
        for (int sep = 1; sep >= 0; sep--) begin
            for (int split = 0; split < 2; split++) begin
                for (int ale = 0; ale < 2; ale++) begin
                    if (sep == 1 && ale == 1) continue;
                    do_reset(sep[0], split[0], ale[0]);
                    for (int k = 0; k < 8; k++) begin
                        logic [7:0] a;
                        a = 8'((k * 37 + cfgi * 11 + 3) % 256);
                        acc_write(a, 16'((a * 16'h0123 + cfgi * 16'h0F0F + k) & 16'hFFFF));
                    end
                    for (int k = 0; k < 8; k++)
                        acc_read(8'((k * 37 + cfgi * 11 + 3) % 256));

                    // R5: strobes with chip select high are ignored
                    w0 = we_cnt; r0 = re_cnt;
                    addr_in = 8'h03;
                    if (!m_sep && m_ale) begin ale_phase(8'h03); cs_n = 1'b1; end
                    bus_wr(1'b1, 16'hBEEF, 1'b0);
                    chk(we_cnt == w0 && mem[3] === expm[3], "R5 write ignored without cs",
                        mem[3], expm[3]);
                    @(negedge clk);
                    strobe_on(1'b1);
                    repeat (6) @(negedge clk);
                    chk(!data_oe && !ad_oe && re_cnt == r0, "R5 read ignored without cs",
                        {data_oe, ad_oe}, 0);
                    strobe_off();
                    repeat (4) @(negedge clk);

                    if (!m_sep && !m_ale) begin
                        // R7: pointer readback
                        bus_wr(1'b0, 16'h003C, 1'b1);
                        r0 = re_cnt;
                        bus_rd(1'b0, v, ok, off);
                        chk(v === 16'h003C && re_cnt == r0, "R7 pointer read", v, 16'h003C);
                    end
                    cfgi++;
                end
            end
        end

        // R1: straps moved after reset have no effect
        do_reset(1'b1, 1'b1, 1'b0);
        strap_sep = 1'b0; strap_split = 1'b0; strap_ale = 1'b1;
        repeat (2) @(negedge clk);
        acc_write(8'h10, 16'h1234);
        chk(mem[8'h10] === 16'h1234, "R1 straps held after reset", mem[8'h10], 16'h1234);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule